// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Line Maintenance

This block is a small direct-mapped data cache that sits between one CPU load/store port and a simple word-wide memory port. Each CPU access carries its own attribute: write-back (stores stay in the cache and mark the line dirty), write-through (stores go to the cache and to memory at once), or uncached (the access goes straight to memory and the cache is neither looked up nor changed). Loads and stores move one 32-bit word.

Two commands let software keep a non-coherent DMA engine in step with the cache. A clean command pushes a dirty line back to memory and keeps it valid, for use before a DMA engine reads a buffer. An invalidate command drops a line without writing it back, for use after a DMA engine has filled a buffer. Both act on the whole 32-byte line that holds the given address.

A request is taken on a cycle where `cpu_req` and `cpu_ready` are both high. Completion is a one-cycle `cpu_done` pulse with `cpu_rdata` valid for loads. Memory beats are single 32-bit transfers, each held until `mem_ack`.

Top module: `dcache_maint`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_ready` is 1, `cpu_done` is 0 and `mem_req` is 0.
- R2: A line is 32 bytes. An address splits into a tag in bits [31:9], an index in bits [8:5] that selects one of 16 lines, and a word offset in bits [4:2]. A load (`cpu_op` = 0) with `cpu_attr` = 0 or 1 that misses on a clean or invalid line makes exactly 8 read beats and no write beats, and returns the memory word.
- R3: A load hit, or a write-back store hit, gives `cpu_done` in the cycle after the request was taken, with no memory beat.
- R4: A store (`cpu_op` = 1) with `cpu_attr` = 0 changes only the cached line and marks it dirty. Memory keeps its old value and later loads return the stored word.
- R5: A load that misses on a valid dirty line first makes 8 write beats that put the old line into memory, then 8 read beats for the new line.
- R6: A store with `cpu_attr` = 1 makes exactly one write beat to its address. On a hit it also updates the cached word. On a miss it does not allocate a line. It never makes a line dirty.
- R7: A load or store with `cpu_attr` = 2 or 3 makes exactly one beat at its address. It neither looks up nor changes the cache, so a load returns the memory word even when the cache holds a newer one.
- R8: A clean (`cpu_op` = 2) that hits a dirty line makes 8 write beats. The line stays valid and clean, and a second clean of the same line makes no beat.
- R9: An invalidate (`cpu_op` = 3) that hits a line drops it without any write beat. The next load of that line refills it from memory.
- R10: A clean or invalidate that misses, and a clean of a line that is not dirty, gives `cpu_done` in the cycle after the request was taken, with no memory beat.
- R11: While a fill, eviction, clean or single memory beat is in progress, `cpu_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request valid |
| cpu_op | input | 2 | 0 load, 1 store, 2 clean line, 3 invalidate line |
| cpu_attr | input | 2 | 0 write-back, 1 write-through, 2 or 3 uncached |
| cpu_addr | input | 32 | Byte address of the word or line |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Block can take a request this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_done |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write data of the beat |
| mem_ack | input | 1 | Memory completes the beat |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
A wrong valid bit shows at the ports on the next load to that line: a lost valid bit causes an unexpected 8-beat refill, and a stale one returns old data with no beat. A wrong dirty bit shows later, when the line is cleaned or replaced. Either eight write beats appear that should not, or they are missing and the memory word that a DMA engine would read keeps its old value. The bench therefore counts the beats of every operation and compares memory content after each clean, invalidate and eviction, so a state error is found within one or two operations on the same index.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CLEAN = 2'd2,
    OP_INVAL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EVICT,
    S_FILL,
    S_SINGLE
  } state_e;

  localparam logic [1:0] ATTR_WB = 2'd0;
  localparam logic [1:0] ATTR_WT = 2'd1;

  function automatic logic attr_uncached(input logic [1:0] a);
    return a[1];
  endfunction
endpackage

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dcm_data_store.sv
module dcm_data_store #(
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 3
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WOFF_W-1:0] rd_woff,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WOFF_W-1:0] wr_woff,
  input  logic [31:0]       wr_data
);
  localparam int DEPTH = 1 << (IDX_W + WOFF_W);

  logic [31:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_idx, wr_woff}] <= wr_data;
  end

  assign rd_data = word_q[{rd_idx, rd_woff}];
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [1:0]        cpu_attr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  import dcm_pkg::*;

  localparam int OFF_W = WOFF_W + 2;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [WOFF_W-1:0] LAST_BEAT = {WOFF_W{1'b1}};

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WOFF_W-1:0] woff_of(input logic [ADDR_W-1:0] a);
    return a[2 +: WOFF_W];
  endfunction
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [TAG_W-1:0] t,
      input logic [IDX_W-1:0] i, input logic [WOFF_W-1:0] w);
    return {t, i, w, 2'b00};
  endfunction

  state_e            state, nxt;
  logic [ADDR_W-1:0] r_addr;
  logic [31:0]       r_wdata;
  op_e               r_op;
  logic [1:0]        r_attr;
  logic [WOFF_W-1:0] beat;
  logic              done_q;
  logic [31:0]       rdata_q;

  // Named internal events, also used by the checker
  logic              accept;
  logic [ADDR_W-1:0] look_addr;
  logic              lookup_hit;
  logic              lookup_dirty;
  logic              beat_done;
  logic              last_beat;

  logic             t_valid, t_dirty;
  logic [TAG_W-1:0] t_tag;
  logic             t_we, t_wv, t_wd;
  logic [TAG_W-1:0] t_wt;
  logic              d_we;
  logic [WOFF_W-1:0] d_woff, d_rd_woff;
  logic [31:0]       d_wdata, d_rdata;
  logic              fin, cap;
  logic [31:0]       cap_val;

  assign cpu_ready    = (state == S_IDLE);
  assign accept       = cpu_req && cpu_ready;
  assign look_addr    = (state == S_IDLE) ? cpu_addr : r_addr;
  assign lookup_hit   = t_valid && (t_tag == tag_of(look_addr));
  assign lookup_dirty = t_valid && t_dirty;
  assign beat_done    = mem_req && mem_ack;
  assign last_beat    = (beat == LAST_BEAT);
  assign d_rd_woff    = (state == S_EVICT) ? beat : woff_of(look_addr);

  dcm_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx_of(look_addr)),
    .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tag(t_tag),
    .wr_en(t_we), .wr_idx(idx_of(look_addr)), .wr_valid(t_wv),
    .wr_dirty(t_wd), .wr_tag(t_wt)
  );

  dcm_data_store #(.IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_data (
    .clk(clk), .rd_idx(idx_of(look_addr)), .rd_woff(d_rd_woff),
    .rd_data(d_rdata), .wr_en(d_we), .wr_idx(idx_of(look_addr)),
    .wr_woff(d_woff), .wr_data(d_wdata)
  );

  always_comb begin
    nxt       = state;
    t_we      = 1'b0;
    t_wv      = t_valid;
    t_wd      = t_dirty;
    t_wt      = t_tag;
    d_we      = 1'b0;
    d_woff    = woff_of(look_addr);
    d_wdata   = cpu_wdata;
    fin       = 1'b0;
    cap       = 1'b0;
    cap_val   = mem_rdata;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = r_addr;
    mem_wdata = r_wdata;
    unique case (state)
      S_IDLE: if (accept) begin
        if (attr_uncached(cpu_attr) && !cpu_op[1]) begin
          nxt = S_SINGLE;
        end else begin
          unique case (op_e'(cpu_op))
            OP_LOAD:
              if (lookup_hit) begin
                fin = 1'b1; cap = 1'b1; cap_val = d_rdata;
              end else nxt = lookup_dirty ? S_EVICT : S_FILL;
            OP_STORE:
              if (lookup_hit) begin
                d_we = 1'b1;
                if (cpu_attr == ATTR_WT) nxt = S_SINGLE;
                else begin t_we = 1'b1; t_wd = 1'b1; fin = 1'b1; end
              end else if (cpu_attr == ATTR_WT) nxt = S_SINGLE;
              else nxt = lookup_dirty ? S_EVICT : S_FILL;
            OP_CLEAN:
              if (lookup_hit && t_dirty) nxt = S_EVICT;
              else fin = 1'b1;
            OP_INVAL: begin
              if (lookup_hit) begin t_we = 1'b1; t_wv = 1'b0; t_wd = 1'b0; end
              fin = 1'b1;
            end
          endcase
        end
      end
      S_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = beat_addr(t_tag, idx_of(r_addr), beat);
        mem_wdata = d_rdata;
        if (mem_ack && last_beat) begin
          if (r_op == OP_CLEAN) begin
            t_we = 1'b1; t_wd = 1'b0; fin = 1'b1; nxt = S_IDLE;
          end else nxt = S_FILL;
        end
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_addr = beat_addr(tag_of(r_addr), idx_of(r_addr), beat);
        if (mem_ack) begin
          d_we    = 1'b1;
          d_woff  = beat;
          d_wdata = (r_op == OP_STORE && beat == woff_of(r_addr)) ? r_wdata : mem_rdata;
          cap     = (beat == woff_of(r_addr));
          if (last_beat) begin
            t_we = 1'b1; t_wv = 1'b1; t_wt = tag_of(r_addr);
            t_wd = (r_op == OP_STORE);
            fin  = 1'b1; nxt = S_IDLE;
          end
        end
      end
      S_SINGLE: begin
        mem_req = 1'b1;
        mem_we  = (r_op == OP_STORE);
        if (mem_ack) begin fin = 1'b1; cap = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      beat    <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_op    <= OP_LOAD;
      r_attr  <= ATTR_WB;
    end else begin
      state  <= nxt;
      done_q <= fin;
      if (cap) rdata_q <= cap_val;
      if (accept) begin
        r_addr  <= cpu_addr;
        r_wdata <= cpu_wdata;
        r_op    <= op_e'(cpu_op);
        r_attr  <= cpu_attr;
      end
      if (beat_done && (state == S_EVICT || state == S_FILL)) beat <= beat + 1'b1;
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [1:0]        cpu_op,
  input logic [1:0]        cpu_attr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              lookup_hit,
  input logic              lookup_dirty
);
  logic take;
  assign take = cpu_req && cpu_ready;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> cpu_ready && !mem_req);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  a_r3_load_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_op == 2'd0 && !cpu_attr[1] && lookup_hit) |=> cpu_done && !mem_req);

  a_r6_wt_store_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_op == 2'd1 && cpu_attr == 2'd1)
      |=> mem_req && mem_we && mem_addr == $past(cpu_addr));

  a_r7_uncached_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpu_op[1] && cpu_attr[1]) |=> mem_req && mem_addr == $past(cpu_addr));

  a_r8_clean_dirty_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_op == 2'd2 && lookup_hit && lookup_dirty) |=> mem_req && mem_we);

  a_r9_inval_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_op == 2'd3) |=> cpu_done && !mem_req);

  a_r10_maint_miss_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpu_op[1] && !lookup_hit) |=> cpu_done && !mem_req);
endmodule

bind dcache_maint dcache_maint_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
  .cpu_attr(cpu_attr), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .lookup_hit(lookup_hit), .lookup_dirty(lookup_dirty)
);

// File: tb/dcache_maint_bench.sv
module dcache_maint_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'd0;
  logic [1:0]  cpu_attr = 2'd0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int rd_total = 0;
  int wr_total = 0;
  logic [31:0] mem [512];

  always #5 clk = ~clk;

  dcache_maint u_dcache_maint (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .cpu_attr(cpu_attr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] initv(input int w);
    return 32'h5A00_0000 + 32'(w) * 32'd13;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int woff);
    return {23'(tag), 4'(idx), 3'(woff), 2'b00};
  endfunction

  function automatic int widx(input logic [31:0] a);
    return int'(a[10:2]);
  endfunction

  // Memory: one beat per request, acknowledged one cycle after it is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 512; i++) mem[i] <= initv(i);
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[10:2]] <= mem_wdata;
        wr_total <= wr_total + 1;
      end else begin
        mem_rdata <= mem[mem_addr[10:2]];
        rd_total <= rd_total + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Issue one request and check beats, latency and (optionally) load data
  task automatic run(input string rq, input logic [1:0] o, input logic [1:0] a,
                     input logic [31:0] ad, input logic [31:0] wd,
                     input int exp_rd, input int exp_wr, input int exp_lat,
                     input bit chk_data, input logic [31:0] exp_data);
    int rd0, wr0, lat;
    bit rdy_ok;
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = o; cpu_attr = a; cpu_addr = ad; cpu_wdata = wd;
    rd0 = rd_total; wr0 = wr_total;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1; rdy_ok = 1'b1;
    while (!cpu_done && lat < 300) begin
      if (cpu_ready) rdy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    check({rq, " completes"}, 32'(lat < 300), 32'd1);
    check({rq, " read beats"}, 32'(rd_total - rd0), 32'(exp_rd));
    check({rq, " write beats"}, 32'(wr_total - wr0), 32'(exp_wr));
    if (exp_lat > 0) check({rq, " latency"}, 32'(lat), 32'(exp_lat));
    if (lat > 1) check({rq, " R11 ready low while busy"}, 32'(rdy_ok), 32'd1);
    if (chk_data) check({rq, " data"}, cpu_rdata, exp_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 ready", 32'(cpu_ready), 32'd1);
    check("R1 done", 32'(cpu_done), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", 32'(cpu_ready), 32'd1);

    // R2: cold fills on every index, write-back and write-through loads
    for (int i = 0; i < 16; i++)
      run("R2 cold load", 2'd0, 2'(i % 2), mk(0, i, i % 8), 0, 8, 0, -1,
          1'b1, initv(widx(mk(0, i, i % 8))));

    // R3: load hits at another word of each line
    for (int i = 0; i < 16; i++)
      run("R3 load hit", 2'd0, 2'd0, mk(0, i, (i + 3) % 8), 0, 0, 0, 1,
          1'b1, initv(widx(mk(0, i, (i + 3) % 8))));

    // R4: write-back stores stay in the cache
    for (int i = 0; i < 16; i++) begin
      run("R4 wb store hit", 2'd1, 2'd0, mk(0, i, 1), 32'hD000_0000 | 32'(i), 0, 0, 1, 1'b0, 0);
      check("R4 memory unchanged", mem[widx(mk(0, i, 1))], initv(widx(mk(0, i, 1))));
      run("R4 load sees store", 2'd0, 2'd0, mk(0, i, 1), 0, 0, 0, 1, 1'b1, 32'hD000_0000 | 32'(i));
    end

    // R8: clean dirty lines 0..7; R10: second clean is a no-op
    for (int i = 0; i < 8; i++) begin
      run("R8 clean dirty", 2'd2, 2'd0, mk(0, i, 5), 0, 0, 8, -1, 1'b0, 0);
      check("R8 memory cleaned", mem[widx(mk(0, i, 1))], 32'hD000_0000 | 32'(i));
      run("R10 clean of clean line", 2'd2, 2'd0, mk(0, i, 0), 0, 0, 0, 1, 1'b0, 0);
      run("R8 line stays valid", 2'd0, 2'd0, mk(0, i, 1), 0, 0, 0, 1, 1'b1, 32'hD000_0000 | 32'(i));
    end

    // R5: replacing dirty lines 8..15 with tag 1
    for (int i = 8; i < 16; i++) begin
      run("R5 dirty replace", 2'd0, 2'd0, mk(1, i, 2), 0, 8, 8, -1, 1'b1, initv(widx(mk(1, i, 2))));
      check("R5 old line in memory", mem[widx(mk(0, i, 1))], 32'hD000_0000 | 32'(i));
    end

    // R9: invalidate drops a dirty line without writeback
    run("R9 dirty store", 2'd1, 2'd0, mk(0, 0, 1), 32'hBAD0_0000, 0, 0, 1, 1'b0, 0);
    run("R9 invalidate hit", 2'd3, 2'd0, mk(0, 0, 6), 0, 0, 0, 1, 1'b0, 0);
    check("R9 memory untouched", mem[widx(mk(0, 0, 1))], 32'hD000_0000);
    run("R9 refill after invalidate", 2'd0, 2'd0, mk(0, 0, 1), 0, 8, 0, -1, 1'b1, 32'hD000_0000);

    // R6: write-through hit, no dirty eviction later, miss without allocation
    run("R6 wt store hit", 2'd1, 2'd1, mk(0, 0, 1), 32'h1234_5678, 0, 1, -1, 1'b0, 0);
    check("R6 memory written", mem[widx(mk(0, 0, 1))], 32'h1234_5678);
    run("R6 cache updated", 2'd0, 2'd0, mk(0, 0, 1), 0, 0, 0, 1, 1'b1, 32'h1234_5678);
    run("R6 line not dirty", 2'd0, 2'd0, mk(2, 0, 0), 0, 8, 0, -1, 1'b1, initv(widx(mk(2, 0, 0))));
    run("R6 wt store miss", 2'd1, 2'd1, mk(3, 1, 4), 32'hCAFE_0001, 0, 1, -1, 1'b0, 0);
    check("R6 miss memory written", mem[widx(mk(3, 1, 4))], 32'hCAFE_0001);
    run("R6 miss did not allocate", 2'd0, 2'd0, mk(3, 1, 4), 0, 8, 0, -1, 1'b1, 32'hCAFE_0001);

    // R7: uncached accesses bypass a dirty cached line
    run("R7 make dirty", 2'd1, 2'd0, mk(0, 2, 1), 32'h7777_0002, 0, 0, 1, 1'b0, 0);
    run("R7 uncached load", 2'd0, 2'd2, mk(0, 2, 1), 0, 1, 0, -1, 1'b1, 32'hD000_0002);
    run("R7 uncached store", 2'd1, 2'd3, mk(0, 2, 1), 32'h4444_0002, 0, 1, -1, 1'b0, 0);
    check("R7 memory written", mem[widx(mk(0, 2, 1))], 32'h4444_0002);
    run("R7 cache untouched", 2'd0, 2'd0, mk(0, 2, 1), 0, 0, 0, 1, 1'b1, 32'h7777_0002);

    // R10: maintenance misses finish at once and leave resident lines alone
    run("R10 clean miss", 2'd2, 2'd0, mk(3, 5, 0), 0, 0, 0, 1, 1'b0, 0);
    run("R10 invalidate miss", 2'd3, 2'd0, mk(3, 5, 0), 0, 0, 0, 1, 1'b0, 0);
    run("R10 resident line kept", 2'd0, 2'd0, mk(0, 5, 1), 0, 0, 0, 1, 1'b1, 32'hD000_0005);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule